// File: doc/BRIEF.md
# Management Register Bridge with Single-Chip and Multichip Addressing

This block sits behind a management-bus slave. It turns decoded bus register accesses into accesses to an internal register space. That space is indexed by a 5-bit device address and a 5-bit register offset. The 5-bit strap address picks one of two modes:

- **Strap address zero.** The block works in pass-through mode. It answers every bus address, and that bus address becomes the internal device address.
- **Strap address non-zero.** The block answers only its own bus address. It then exposes just two registers: a command register and a data register. Every internal access goes through them.

In the indirect mode the host sets a busy bit when it issues a command and then polls. The block clears busy once the internal access is done. For a write, the host fills the data register before issuing the command. For a read, the result is in the data register once busy is low. The internal side is a single-cycle request port: write data goes out with the request, and read data is sampled in the same cycle.

Top module: `mgmt_reg_bridge`

## Requirements
- R1: With `strap_addr` equal to 0, every bus strobe becomes an internal request in the same cycle. The bus address is the device, the bus register number is the offset, and the write flag and write data pass straight through.
- R2: With a non-zero `strap_addr`, a strobe whose bus address differs from `strap_addr` produces no internal request, no register change and no read response.
- R3: In indirect mode, register 0 of the own address is the command register and register 1 is the data register. A read of any other register number returns 0xFFFF, and a write to one has no effect.
- R4: Command word layout:
  - bit 15 is busy;
  - bit 12 is the clause-22 flag;
  - bits 11:10 are the opcode, where 1 means write and 2 means read when bit 12 is set;
  - bits 9:5 are the device;
  - bits 4:0 are the offset.
- R5: An indirect write sends the current data register contents to the addressed internal register. An indirect read loads the internal register value into the data register by the time busy reads 0.
- R6: Busy reads 1 for exactly LATENCY (default 4) consecutive cycles after a command with bit 15 set is accepted. The single internal request is issued in the last of those cycles.
- R7: While busy is set, writes to the command register and to the data register are ignored, and the running operation completes unchanged.
- R8: A command with bit 12 clear, or with an opcode other than 1 or 2, makes no internal request. When it completes, the data register holds 0xFFFF.
- R9: A read of the command register returns the last accepted command word, with bit 15 replaced by the live busy flag.
- R10: A command-register write with bit 15 clear, made while idle, stores the word without starting an access.
- R11: After reset the command and data registers read 0x0000 and busy is clear.
- R12: `bus_rvalid` pulses in the cycle after each answered read strobe, with `bus_rdata` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Strapped bus address; zero selects pass-through mode |
| bus_valid | input | 1 | One-cycle access strobe from the bus slave |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_phy | input | 5 | Bus address of the access |
| bus_reg | input | 5 | Register number of the access |
| bus_wdata | input | 16 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 16 | Read response data |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_dev | output | 5 | Internal device address |
| int_off | output | 5 | Internal register offset |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data, valid in the request cycle |

## Verification
Completion of a running command and a host write of a new command can fall in the same cycle. The busy flag drops at the edge that closes the last busy cycle, so a command written during that cycle still sees busy set.

The bench provokes this case in two steps:
1. It issues a command and then makes three polling reads, each of which sees busy.
2. It writes a second command in the fourth cycle.

The test passes when the readback still shows the first command with busy cleared, and exactly one internal request has occurred. A command written one cycle later must then be accepted.

// File: rtl/mgmt_reg_bridge.sv
module mgmt_reg_bridge #(
  parameter int LATENCY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap_addr,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_phy,
  input  logic [4:0]  bus_reg,
  input  logic [15:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [15:0] bus_rdata,
  output logic        int_req,
  output logic        int_we,
  output logic [4:0]  int_dev,
  output logic [4:0]  int_off,
  output logic [15:0] int_wdata,
  input  logic [15:0] int_rdata
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   cmd_q;
  logic [15:0]   data_q;

  wire direct  = (strap_addr == 5'd0);
  wire own_hit = bus_valid && !direct && (bus_phy == strap_addr);
  wire cmd_wr  = own_hit && bus_write && (bus_reg == 5'd0) && !busy_q;
  wire dat_wr  = own_hit && bus_write && (bus_reg == 5'd1) && !busy_q;
  wire start   = cmd_wr && bus_wdata[15];
  wire op_wr   = cmd_q[12] && (cmd_q[11:10] == 2'd1);
  wire op_rd   = cmd_q[12] && (cmd_q[11:10] == 2'd2);
  wire last    = busy_q && (cnt_q == '0);
  wire answer  = bus_valid && !bus_write && (direct || bus_phy == strap_addr);

  assign int_req   = direct ? bus_valid : (last && (op_wr || op_rd));
  assign int_we    = direct ? bus_write : op_wr;
  assign int_dev   = direct ? bus_phy   : cmd_q[9:5];
  assign int_off   = direct ? bus_reg   : cmd_q[4:0];
  assign int_wdata = direct ? bus_wdata : data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
      cmd_q  <= bus_wdata;
    end else if (cmd_wr) begin
      cmd_q  <= bus_wdata;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (dat_wr)
      data_q <= bus_wdata;
    else if (last && op_rd)
      data_q <= int_rdata;
    else if (last && !op_wr)
      data_q <= 16'hFFFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= answer;
      if (answer) begin
        if (direct)                bus_rdata <= int_rdata;
        else if (bus_reg == 5'd0)  bus_rdata <= {busy_q, cmd_q[14:0]};
        else if (bus_reg == 5'd1)  bus_rdata <= data_q;
        else                       bus_rdata <= 16'hFFFF;
      end
    end
  end
endmodule

// File: rtl/mgmt_reg_bridge_chk.sv
module mgmt_reg_bridge_chk #(
  parameter int LATENCY = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  strap_addr,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [4:0]  bus_phy,
  input logic [4:0]  bus_reg,
  input logic        bus_rvalid,
  input logic        int_req,
  input logic        int_we,
  input logic [4:0]  int_dev,
  input logic [4:0]  int_off,
  input logic        busy_q,
  input logic [15:0] cmd_q
);
  int blen;
  logic seen_busy;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blen <= 0;
      seen_busy <= 1'b0;
    end else begin
      blen <= busy_q ? blen + 1 : 0;
      seen_busy <= busy_q;
    end
  end

  a_r1_direct_map: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_addr == 5'd0 && bus_valid) |->
      (int_req && int_dev == bus_phy && int_off == bus_reg && int_we == bus_write));

  a_r2_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_addr != 5'd0 && bus_valid && !bus_write && bus_phy != strap_addr) |=> !bus_rvalid);

  a_r6_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_addr != 5'd0 && !busy_q) |-> !int_req);

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_busy && !busy_q) |-> (blen == LATENCY));

  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_q));

  a_r8_bad_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_addr != 5'd0 && busy_q && !(cmd_q[12] && (cmd_q[11:10] == 2'd1 || cmd_q[11:10] == 2'd2)))
      |-> !int_req);

  a_r12_rvalid_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (strap_addr == 5'd0 || bus_phy == strap_addr)) |=> bus_rvalid);
endmodule

bind mgmt_reg_bridge mgmt_reg_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_phy(bus_phy), .bus_reg(bus_reg),
  .bus_rvalid(bus_rvalid), .int_req(int_req), .int_we(int_we),
  .int_dev(int_dev), .int_off(int_off), .busy_q(busy_q), .cmd_q(cmd_q)
);

// File: tb/sim_mgmt_reg_bridge.sv
`timescale 1ns/1ps
module sim_mgmt_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = 5'd0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_phy = '0, bus_reg = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [15:0] bus_rdata;
  logic        int_req, int_we;
  logic [4:0]  int_dev, int_off;
  logic [15:0] int_wdata, int_rdata;

  logic [15:0] mem [0:1023];
  int n_req = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mgmt_reg_bridge u0 (.*);

  assign int_rdata = mem[{int_dev, int_off}];
  always @(posedge clk) if (rst_n && int_req) begin
    n_req <= n_req + 1;
    if (int_we) mem[{int_dev, int_off}] <= int_wdata;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    strap_addr = s; rst_n = 1'b0; bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bwr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_phy = p; bus_reg = r; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input logic [4:0] p, input logic [4:0] r,
                     output logic [15:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_phy = p; bus_reg = r;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wait_idle(input logic [4:0] p);
    logic [15:0] d; logic v;
    for (int i = 0; i < 20; i++) begin
      brd(p, 5'd0, d, v);
      if (!d[15]) break;
    end
  endtask

  // R11 R12
  task automatic t_reset;
    logic [15:0] d; logic v;
    do_reset(5'd5);
    brd(5'd5, 5'd0, d, v);
    chk("R12 rvalid after read", {15'd0, v}, 16'd1);
    chk("R11 cmd after reset", d, 16'h0000);
    brd(5'd5, 5'd1, d, v);
    chk("R11 data after reset", d, 16'h0000);
  endtask

  // R1
  task automatic t_direct;
    logic [15:0] d; logic v;
    do_reset(5'd0);
    bwr(5'd3, 5'd7, 16'hA55A);
    chk("R1 direct write landed", mem[{5'd3, 5'd7}], 16'hA55A);
    mem[{5'd12, 5'd30}] = 16'h0F0F;
    brd(5'd12, 5'd30, d, v);
    chk("R1 direct read", d, 16'h0F0F);
  endtask

  // R2 R3
  task automatic t_foreign;
    logic [15:0] d; logic v; int r0;
    do_reset(5'd5);
    r0 = n_req;
    bwr(5'd3, 5'd0, 16'h9400);
    brd(5'd3, 5'd0, d, v);
    chk("R2 foreign read no rvalid", {15'd0, v}, 16'd0);
    brd(5'd5, 5'd0, d, v);
    chk("R2 foreign write no effect", d, 16'h0000);
    chk("R2 no internal request", 16'(n_req - r0), 16'd0);
    bwr(5'd5, 5'd9, 16'h1234);
    brd(5'd5, 5'd9, d, v);
    chk("R3 other reg reads FFFF", d, 16'hFFFF);
  endtask

  // R4 R5 R6 R9
  task automatic t_ind_write;
    logic [15:0] d; logic v; int nb;
    do_reset(5'd5);
    bwr(5'd5, 5'd1, 16'hBEEF);
    bwr(5'd5, 5'd0, 16'h9000 | (16'd1 << 10) | (16'd6 << 5) | 16'd21);
    nb = 0;
    for (int i = 0; i < 6; i++) begin
      brd(5'd5, 5'd0, d, v);
      if (d[15]) nb++;
    end
    chk("R6 busy cycles", 16'(nb), 16'd4);
    chk("R9 cmd readback", d, 16'h1000 | (16'd1 << 10) | (16'd6 << 5) | 16'd21);
    chk("R5 R4 indirect write landed", mem[{5'd6, 5'd21}], 16'hBEEF);
  endtask

  task automatic t_ind_read;
    logic [15:0] d; logic v;
    mem[{5'd9, 5'd17}] = 16'h1234;
    bwr(5'd5, 5'd0, 16'h9000 | (16'd2 << 10) | (16'd9 << 5) | 16'd17);
    wait_idle(5'd5);
    brd(5'd5, 5'd1, d, v);
    chk("R5 indirect read result", d, 16'h1234);
  endtask

  // R7
  task automatic t_busy_ignore;
    logic [15:0] d; logic v;
    bwr(5'd5, 5'd1, 16'h7777);
    bwr(5'd5, 5'd0, 16'h9400 | (16'd2 << 5) | 16'd2);
    bwr(5'd5, 5'd0, 16'h9400 | (16'd3 << 5) | 16'd3);
    bwr(5'd5, 5'd1, 16'h1111);
    wait_idle(5'd5);
    chk("R7 first op done", mem[{5'd2, 5'd2}], 16'h7777);
    chk("R7 second cmd ignored", mem[{5'd3, 5'd3}], 16'h0000);
    brd(5'd5, 5'd1, d, v);
    chk("R7 data write ignored", d, 16'h7777);
  endtask

  // R6 R7 collision at completion cycle
  task automatic t_collide;
    logic [15:0] d; logic v; int r0;
    r0 = n_req;
    bwr(5'd5, 5'd0, 16'h9400 | (16'd4 << 5) | 16'd4);
    for (int i = 0; i < 3; i++) brd(5'd5, 5'd0, d, v);
    bwr(5'd5, 5'd0, 16'h9400 | (16'd8 << 5) | 16'd8);
    brd(5'd5, 5'd0, d, v);
    chk("R7 cmd at last busy cycle ignored", d, 16'h1400 | (16'd4 << 5) | 16'd4);
    chk("R6 one request", 16'(n_req - r0), 16'd1);
    bwr(5'd5, 5'd0, 16'h9400 | (16'd8 << 5) | 16'd8);
    brd(5'd5, 5'd0, d, v);
    chk("R7 cmd after completion accepted", d, 16'h9400 | (16'd8 << 5) | 16'd8);
    wait_idle(5'd5);
  endtask

  // R8 R10
  task automatic t_bad;
    logic [15:0] d; logic v; int r0;
    r0 = n_req;
    bwr(5'd5, 5'd0, 16'h8000 | (16'd2 << 10) | (16'd9 << 5) | 16'd17);
    wait_idle(5'd5);
    brd(5'd5, 5'd1, d, v);
    chk("R8 no clause22 gives FFFF", d, 16'hFFFF);
    bwr(5'd5, 5'd1, 16'h0000);
    bwr(5'd5, 5'd0, 16'h9C00 | (16'd9 << 5) | 16'd17);
    wait_idle(5'd5);
    brd(5'd5, 5'd1, d, v);
    chk("R8 opcode 3 gives FFFF", d, 16'hFFFF);
    chk("R8 no internal request", 16'(n_req - r0), 16'd0);
    bwr(5'd5, 5'd0, 16'h1400 | (16'd1 << 5) | 16'd1);
    brd(5'd5, 5'd0, d, v);
    chk("R10 stored without busy", d, 16'h1400 | (16'd1 << 5) | 16'd1);
    repeat (6) @(negedge clk);
    chk("R10 no request", 16'(n_req - r0), 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    t_reset();
    t_direct();
    t_foreign();
    t_ind_write();
    t_ind_read();
    t_busy_ignore();
    t_collide();
    t_bad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule